// File: doc/BRIEF.md
# Cascadable BCD Decade Counter Stage

This block is one decimal digit of a synchronous counter. A 4-bit register steps through the 8421 BCD codes 0 to 9 and then returns to 0. An active-low load strobe copies four data inputs into the register. Two count enables must both be high for the register to advance. The *parallel* enable is normally shared by every digit. The *trickle* enable receives the carry from the digit below.

A terminal-count output is high when the digit reads 9 and its trickle enable is high. Wiring each stage's terminal count to the trickle enable of the next stage builds a multi-digit decimal counter. All stages share one clock, one load strobe and one parallel enable.

A build-time parameter selects the reset style:

- **Asynchronous:** a low reset clears the digit at once, without waiting for a clock edge.
- **Synchronous:** a low reset clears the digit at the next rising clock edge.

Every other change of state happens on the rising edge. The control inputs are resolved with fixed priority: clear, then load, then count, then hold.

Top module: `bcd_cnt_stage`

## Requirements
- R1: With reset high, load high and both enables high, the count advances by one per rising edge through 0,1,...,9, and 9 is followed by 0.
- R2: With ASYNC_RESET=1, a low on rst_n_i forces the count to 0 at once, before any clock edge. The count stays 0 while rst_n_i is low, whatever load_n_i, data_i or the enables do.
- R3: With ASYNC_RESET=0, a low on rst_n_i leaves the count unchanged until the next rising edge. At that edge the count becomes 0, even if load_n_i is low or both enables are high.
- R4: With reset inactive and load_n_i low, the next rising edge copies data_i into the count, whatever the count enables are.
- R5: With reset and load inactive, a low on cnt_en_par_i or on cnt_en_trk_i holds the count unchanged across the edge.
- R6: tc_o is high exactly when cnt_en_trk_i is high and the count is 9. It follows cnt_en_trk_i without waiting for a clock edge, and load_n_i and cnt_en_par_i have no effect on it.
- R7: A loaded value from 10 to 15 advances by plain binary increment when counting, and 15 is followed by 0.
- R8: Two stages chained through tc_o form a two-digit counter: the upper digit advances only on the edge where the lower digit wraps from 9 to 0, and 99 is followed by 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_n_i | input | 1 | Active-low reset; asynchronous or synchronous according to ASYNC_RESET |
| load_n_i | input | 1 | Active-low parallel load strobe |
| data_i | input | 4 | Value copied into the count on a load |
| cnt_en_par_i | input | 1 | Parallel count enable, shared across stages |
| cnt_en_trk_i | input | 1 | Trickle count enable; also gates tc_o |
| count_o | output | 4 | Current digit value |
| tc_o | output | 1 | Terminal count: digit at 9 and trickle enable high |

## Verification
The assertions check the following on every cycle:

- the 9-to-0 wrap;
- the load taking data_i;
- the hold when either enable is low;
- the binary step of the codes 10 to 15;
- the reset clearing in both variants;
- the rule that tc_o is never high unless the digit is 9 and the trickle enable is high.

Some behaviours can only be shown by the bench's scenarios, which compare against a behavioural model:

- the immediate clear from a reset raised in the middle of a cycle;
- the synchronous variant keeping its value until the edge after reset is raised;
- tc_o following the trickle enable between edges while it ignores load and the parallel enable;
- the two-digit rollover from 99 to 00.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;

    parameter int CNT_W = 4;

    typedef enum logic [1:0] {
        MODE_CLEAR = 2'd0,
        MODE_LOAD  = 2'd1,
        MODE_COUNT = 2'd2,
        MODE_HOLD  = 2'd3
    } cnt_mode_e;

    typedef struct packed {
        logic [CNT_W-1:0] value;
        logic             at_term;
    } cnt_state_t;

endpackage

// File: rtl/bcd_cnt_mode.sv
module bcd_cnt_mode
    import bcd_cnt_pkg::*;
(
    input  logic      sync_clear_i,
    input  logic      load_n_i,
    input  logic      en_par_i,
    input  logic      en_trk_i,
    output cnt_mode_e mode_o
);

    // Fixed priority: clear, load, count, hold.
    always_comb begin
        if (sync_clear_i) begin
            mode_o = MODE_CLEAR;
        end else if (!load_n_i) begin
            mode_o = MODE_LOAD;
        end else if (en_par_i && en_trk_i) begin
            mode_o = MODE_COUNT;
        end else begin
            mode_o = MODE_HOLD;
        end
    end

endmodule

// File: rtl/bcd_cnt_step.sv
module bcd_cnt_step
    import bcd_cnt_pkg::*;
#(
    parameter int MODULUS = 10
) (
    input  cnt_mode_e        mode_i,
    input  logic [CNT_W-1:0] cur_i,
    input  logic [CNT_W-1:0] data_i,
    output logic [CNT_W-1:0] next_o
);

    localparam logic [CNT_W-1:0] LAST_CODE = CNT_W'(MODULUS - 1);

    logic [CNT_W-1:0] incr;

    // The last legal code wraps to zero. Any other code, including the
    // out-of-range codes, steps by binary increment, so the all-ones
    // code overflows to zero.
    always_comb begin
        if (cur_i == LAST_CODE) begin
            incr = '0;
        end else begin
            incr = cur_i + CNT_W'(1);
        end
    end

    always_comb begin
        unique case (mode_i)
            MODE_CLEAR: next_o = '0;
            MODE_LOAD:  next_o = data_i;
            MODE_COUNT: next_o = incr;
            default:    next_o = cur_i;
        endcase
    end

endmodule

// File: rtl/bcd_cnt_term.sv
module bcd_cnt_term (
    input  logic at_term_i,
    input  logic en_trk_i,
    output logic tc_o
);

    // Combinational path from the trickle enable, so the carry ripples
    // through a chain of stages within one cycle.
    assign tc_o = at_term_i & en_trk_i;

endmodule

// File: rtl/bcd_cnt_stage.sv
module bcd_cnt_stage
    import bcd_cnt_pkg::*;
#(
    parameter int MODULUS     = 10,
    parameter bit ASYNC_RESET = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             load_n_i,
    input  logic [CNT_W-1:0] data_i,
    input  logic             cnt_en_par_i,
    input  logic             cnt_en_trk_i,
    output logic [CNT_W-1:0] count_o,
    output logic             tc_o
);

    localparam logic [CNT_W-1:0] LAST_CODE = CNT_W'(MODULUS - 1);

    cnt_state_t       state_d;
    cnt_state_t       state_q;
    cnt_mode_e        mode;
    logic             sync_clear;
    logic [CNT_W-1:0] value_next;

    // Only the synchronous variant resolves reset through the mode logic.
    assign sync_clear = ASYNC_RESET ? 1'b0 : ~rst_n_i;

    bcd_cnt_mode mode_i (
        .sync_clear_i (sync_clear),
        .load_n_i     (load_n_i),
        .en_par_i     (cnt_en_par_i),
        .en_trk_i     (cnt_en_trk_i),
        .mode_o       (mode)
    );

    bcd_cnt_step #(
        .MODULUS (MODULUS)
    ) step_i (
        .mode_i (mode),
        .cur_i  (state_q.value),
        .data_i (data_i),
        .next_o (value_next)
    );

    always_comb begin
        state_d         = state_q;
        state_d.value   = value_next;
        state_d.at_term = (value_next == LAST_CODE);
    end

    generate
        if (ASYNC_RESET) begin : g_async_rst
            always_ff @(posedge clk_i or negedge rst_n_i) begin
                if (!rst_n_i) begin
                    state_q <= '0;
                end else begin
                    state_q <= state_d;
                end
            end
        end else begin : g_sync_rst
            always_ff @(posedge clk_i) begin
                state_q <= state_d;
            end
        end
    endgenerate

    bcd_cnt_term term_i (
        .at_term_i (state_q.at_term),
        .en_trk_i  (cnt_en_trk_i),
        .tc_o      (tc_o)
    );

    assign count_o = state_q.value;

endmodule

// File: rtl/bcd_cnt_stage_chk.sv
module bcd_cnt_stage_chk
    import bcd_cnt_pkg::*;
#(
    parameter int MODULUS     = 10,
    parameter bit ASYNC_RESET = 1'b1
) (
    input logic             clk_i,
    input logic             rst_n_i,
    input logic             load_n_i,
    input logic [CNT_W-1:0] data_i,
    input logic             cnt_en_par_i,
    input logic             cnt_en_trk_i,
    input logic [CNT_W-1:0] count_o,
    input logic             tc_o
);

    localparam logic [CNT_W-1:0] LAST_CODE = CNT_W'(MODULUS - 1);
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

    assert_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (load_n_i && cnt_en_par_i && cnt_en_trk_i && count_o == LAST_CODE)
        |=> count_o == '0);

    assert_load_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !load_n_i |=> count_o == $past(data_i));

    assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (load_n_i && !(cnt_en_par_i && cnt_en_trk_i)) |=> $stable(count_o));

    assert_tc_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        tc_o |-> (count_o == LAST_CODE && cnt_en_trk_i));

    assert_tc_trk_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !cnt_en_trk_i |-> !tc_o);

    assert_binary_step_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (load_n_i && cnt_en_par_i && cnt_en_trk_i && count_o > LAST_CODE)
        |=> count_o == $past(count_o) + ONE);

    generate
        if (ASYNC_RESET) begin : g_async_chk
            assert_async_clear_R2: assert property (@(posedge clk_i)
                !rst_n_i |-> count_o == '0);
        end else begin : g_sync_chk
            assert_sync_clear_R3: assert property (@(posedge clk_i)
                !rst_n_i |=> count_o == '0);
        end
    endgenerate

endmodule

bind bcd_cnt_stage bcd_cnt_stage_chk #(
    .MODULUS     (MODULUS),
    .ASYNC_RESET (ASYNC_RESET)
) chk_i (
    .clk_i        (clk_i),
    .rst_n_i      (rst_n_i),
    .load_n_i     (load_n_i),
    .data_i       (data_i),
    .cnt_en_par_i (cnt_en_par_i),
    .cnt_en_trk_i (cnt_en_trk_i),
    .count_o      (count_o),
    .tc_o         (tc_o)
);

// File: tb/bcd_cnt_stage_tb_top.sv
`timescale 1ns/1ps
module bcd_cnt_stage_tb_top;

    logic       clk = 1'b0;
    logic       arst_n;
    logic       srst_n;
    logic       load_n;
    logic [3:0] data_lo;
    logic [3:0] data_hi;
    logic       par;
    logic       trk;
    logic [3:0] cnt_lo;
    logic [3:0] cnt_hi;
    logic [3:0] cnt_s;
    logic       tc_lo;
    logic       tc_hi;
    logic       tc_s;

    int    checks = 0;
    int    fails  = 0;
    int    m_lo   = 0;
    int    m_hi   = 0;
    int    m_s    = 0;
    bit    done   = 1'b0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    // Lower digit, asynchronous reset
    bcd_cnt_stage #(.MODULUS(10), .ASYNC_RESET(1'b1)) dut_i (
        .clk_i(clk), .rst_n_i(arst_n), .load_n_i(load_n), .data_i(data_lo),
        .cnt_en_par_i(par), .cnt_en_trk_i(trk), .count_o(cnt_lo), .tc_o(tc_lo));

    // Upper digit, chained through the terminal count
    bcd_cnt_stage #(.MODULUS(10), .ASYNC_RESET(1'b1)) dut_hi_i (
        .clk_i(clk), .rst_n_i(arst_n), .load_n_i(load_n), .data_i(data_hi),
        .cnt_en_par_i(par), .cnt_en_trk_i(tc_lo), .count_o(cnt_hi), .tc_o(tc_hi));

    // Synchronous-reset variant
    bcd_cnt_stage #(.MODULUS(10), .ASYNC_RESET(1'b0)) dut_sync_i (
        .clk_i(clk), .rst_n_i(srst_n), .load_n_i(load_n), .data_i(data_lo),
        .cnt_en_par_i(par), .cnt_en_trk_i(trk), .count_o(cnt_s), .tc_o(tc_s));

    function automatic int nxt(int cur, bit clr, bit ld_n, int d, bit p, bit t);
        if (clr)        return 0;
        if (!ld_n)      return d;
        if (p && t)     return (cur == 9) ? 0 : (cur + 1) % 16;
        return cur;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        bit e_tc_lo;
        e_tc_lo = trk && (m_lo == 9);
        check(cur_req, "lower count", int'(cnt_lo), m_lo);
        check("R6", "lower tc", int'(tc_lo), int'(e_tc_lo));
        check(cur_req, "upper count", int'(cnt_hi), m_hi);
        check("R6", "upper tc", int'(tc_hi), int'(e_tc_lo && (m_hi == 9)));
        check(cur_req, "sync count", int'(cnt_s), m_s);
        check("R6", "sync tc", int'(tc_s), int'(trk && (m_s == 9)));
    endtask

    task automatic tick();
        int  n_lo;
        int  n_hi;
        int  n_s;
        bit  c_lo;
        c_lo = trk && (m_lo == 9);
        n_lo = !arst_n ? 0 : nxt(m_lo, 1'b0, load_n, int'(data_lo), par, trk);
        n_hi = !arst_n ? 0 : nxt(m_hi, 1'b0, load_n, int'(data_hi), par, c_lo);
        n_s  = nxt(m_s, !srst_n, load_n, int'(data_lo), par, trk);
        @(posedge clk);
        #1;
        m_lo = n_lo;
        m_hi = n_hi;
        m_s  = n_s;
        compare_all();
    endtask

    task automatic load_pair(int lo, int hi);
        load_n  = 1'b0;
        data_lo = 4'(lo);
        data_hi = 4'(hi);
        tick();
        load_n  = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        arst_n = 1'b0; srst_n = 1'b0; load_n = 1'b1;
        data_lo = 4'd0; data_hi = 4'd0; par = 1'b0; trk = 1'b0;

        // Reset state of both variants (R2, R3)
        cur_req = "R2 R3 reset";
        tick();
        arst_n = 1'b1; srst_n = 1'b1;
        tick();

        // R1 and R8: free counting through several wraps
        cur_req = "R1 R8";
        par = 1'b1; trk = 1'b1;
        for (int i = 0; i < 25; i++) tick();

        // R5: hold with each enable low
        cur_req = "R5 par low";
        par = 1'b0;
        for (int i = 0; i < 3; i++) tick();
        par = 1'b1; trk = 1'b0;
        cur_req = "R5 trk low";
        for (int i = 0; i < 3; i++) tick();
        trk = 1'b1;

        // R4: load while counting, and load with enables low
        cur_req = "R4";
        load_pair(7, 3);
        for (int i = 0; i < 4; i++) tick();
        par = 1'b0;
        load_pair(2, 5);
        tick();
        par = 1'b1;

        // R6: tc between edges follows trk, ignores load and par
        cur_req = "R6";
        load_pair(9, 4);
        par = 1'b0;
        #1; check("R6", "tc with trk high", int'(tc_lo), 1);
        trk = 1'b0;
        #0.5; check("R6", "tc after trk low", int'(tc_lo), 0);
        trk = 1'b1;
        load_n = 1'b0; data_lo = 4'd1;
        #0.5; check("R6", "tc ignores load and par", int'(tc_lo), 1);
        load_n = 1'b1; par = 1'b1;

        // R7: out-of-range codes step in binary, 15 wraps to 0
        cur_req = "R7";
        load_pair(10, 0);
        for (int i = 0; i < 7; i++) tick();

        // R8: two-digit rollover 99 -> 00
        cur_req = "R8";
        load_pair(9, 9);
        par = 1'b0;
        #0.5; check("R8", "upper tc at 99", int'(tc_hi), 1);
        par = 1'b1;
        tick();
        check("R8", "rollover lower", int'(cnt_lo), 0);
        check("R8", "rollover upper", int'(cnt_hi), 0);
        for (int i = 0; i < 12; i++) tick();

        // R2, R3: reset raised mid-cycle with load pending
        cur_req = "R2 R3 midcycle";
        load_pair(6, 8);
        load_n = 1'b0; data_lo = 4'd5; data_hi = 4'd5;
        arst_n = 1'b0; srst_n = 1'b0;
        #0.5;
        m_lo = 0; m_hi = 0;
        check("R2", "async clear before edge", int'(cnt_lo), 0);
        check("R2", "async clear upper", int'(cnt_hi), 0);
        check("R3", "sync held before edge", int'(cnt_s), 6);
        tick();
        tick();
        load_n = 1'b1;
        arst_n = 1'b1; srst_n = 1'b1;
        cur_req = "R1 after reset";
        for (int i = 0; i < 4; i++) tick();

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule